// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block performs one 32-bit saturating arithmetic operation per cycle, selected by an opcode. It offers signed and unsigned addition and subtraction that clamp to the limits of their number range, a signed doubling, and a clamp of a value to a chosen bit position. The clamp comes in a signed and an unsigned form, and each form can act on the whole word or on the two 16-bit halves independently. A plain wrapping signed add is also provided. It returns the modular sum but still reports signed overflow.

The result is combinational from the operands. Every clamping event, and every signed overflow of the wrapping add, sets a single sticky flag. The flag is registered and is visible on the cycle after the event. It stays set until the clear input is raised. When a set and a clear arrive in the same cycle, the set wins. A processor datapath uses the flag to find out whether any step of a sequence lost precision.

Top module: `sat_alu`

## Requirements
- R1: Opcode 1 (signed add) returns a+b. When both operands share a sign and the sum's sign differs, it returns 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and it flags saturation.
- R2: Opcode 2 (signed subtract) returns a−b. When the operands differ in sign and the difference's sign differs from a, it clamps like R1 and flags saturation.
- R3: Opcode 3 (signed doubling of a) returns 0x7FFFFFFF for a ≥ 0x40000000 and 0x80000000 for a ≤ 0xC0000000 (signed), and flags saturation in both cases. Otherwise it returns a shifted left by one.
- R4: Opcode 4 (unsigned add) returns 0xFFFFFFFF on carry out. Opcode 5 (unsigned subtract) returns 0 on borrow. Both flag saturation in those cases and otherwise return the modular result.
- R5: Opcode 6 (signed clamp to position s = pos) shifts a right arithmetically by s. If the upper part is > 0 it returns 2^s−1, if the upper part is < −1 it returns ~(2^s−1), and in both cases it flags saturation. Otherwise it returns a unchanged.
- R6: Opcode 8 (unsigned clamp to position s) returns 0 for a negative a and 2^s−1 for a > 2^s−1, flagging saturation in both cases. Otherwise it returns a.
- R7: Opcodes 7 and 9 apply R5 and R6 respectively to each sign-extended 16-bit half of a. The low result goes to bits [15:0] and the high result to bits [31:16]. Saturation in either half flags.
- R8: Opcode 10 returns the wrapped sum a+b and flags saturation on signed overflow as defined in R1.
- R9: The sticky flag reads 1 from the cycle after any flagged event. An operation that flags nothing leaves it unchanged. Opcode 0 and opcodes 11–15 return 0 and flag nothing.
- R10: Raising the clear input for a cycle makes the flag 0 on the next cycle, unless a flagged event happens in that same cycle, in which case the flag reads 1.
- R11: After reset the sticky flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Clamp bit position s |
| clr_i | input | 1 | Clear request for the sticky flag |
| res_o | output | 32 | Operation result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
Each arithmetic operation is driven with a positive overflow, a negative overflow and an in-range value. This shows that the block picks the correct clamp direction and does not clamp values that fit. Doubling is tried exactly at 0x40000000 and 0xC0000000 and one step inside each limit, which separates ≥ from > at both boundaries. The position clamps are tried at positions 0 and 7 or 8. They use values just inside the range, just outside it, and exactly at −2^s, so that the "< −1" test is not confused with "< 0". The dual-halfword forms use halves that saturate in opposite directions, which exposes a swapped or unextended half. Directed sequences then check that the flag persists through non-saturating operations, that clear resets it, and that a set wins over a clear in the same cycle.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             op_i,
  input  logic [DW-1:0]          a_i,
  input  logic [DW-1:0]          b_i,
  input  logic [$clog2(DW)-1:0]  pos_i,
  input  logic                   clr_i,
  output logic [DW-1:0]          res_o,
  output logic                   sat_flag_o
);
  localparam int HW = DW / 2;
  localparam int PW = $clog2(DW);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] QPOS = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] QNEG = {2'b11, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};

  localparam logic [3:0] OP_QADD = 4'd1, OP_QSUB = 4'd2, OP_QDBL = 4'd3,
                         OP_UADD = 4'd4, OP_USUB = 4'd5, OP_SSAT = 4'd6,
                         OP_SSAT2 = 4'd7, OP_USAT = 4'd8, OP_USAT2 = 4'd9,
                         OP_ADDW = 4'd10;

  // {saturated, value}
  function automatic logic [DW:0] clamp_s(input logic [DW-1:0] v, input logic [PW-1:0] s);
    logic signed [DW-1:0] top;
    logic [DW-1:0] mask;
    top  = $signed(v) >>> s;
    mask = (ONE << s) - ONE;
    if (top > 0)       clamp_s = {1'b1, mask};
    else if (top < -1) clamp_s = {1'b1, ~mask};
    else               clamp_s = {1'b0, v};
  endfunction

  function automatic logic [DW:0] clamp_u(input logic [DW-1:0] v, input logic [PW-1:0] s);
    logic [DW-1:0] mask;
    mask = (ONE << s) - ONE;
    if (v[DW-1])       clamp_u = {1'b1, {DW{1'b0}}};
    else if (v > mask) clamp_u = {1'b1, mask};
    else               clamp_u = {1'b0, v};
  endfunction

  logic [DW:0]   uadd;
  logic [DW-1:0] sum, dif, udif;
  logic          add_ovf, sub_ovf;
  logic [DW-1:0] lo_ext, hi_ext;
  logic [DW:0]   ws, wu, ls, hs, lu, hu;
  logic [DW-1:0] res_w;
  logic          sat_w;
  logic          flag_q;

  assign uadd    = {1'b0, a_i} + {1'b0, b_i};
  assign sum     = uadd[DW-1:0];
  assign dif     = a_i - b_i;
  assign udif    = dif;
  assign add_ovf = (a_i[DW-1] == b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);
  assign sub_ovf = (a_i[DW-1] != b_i[DW-1]) && (dif[DW-1] != a_i[DW-1]);
  assign lo_ext  = {{HW{a_i[HW-1]}}, a_i[HW-1:0]};
  assign hi_ext  = {{HW{a_i[DW-1]}}, a_i[DW-1:HW]};
  assign ws = clamp_s(a_i, pos_i);
  assign wu = clamp_u(a_i, pos_i);
  assign ls = clamp_s(lo_ext, pos_i);
  assign hs = clamp_s(hi_ext, pos_i);
  assign lu = clamp_u(lo_ext, pos_i);
  assign hu = clamp_u(hi_ext, pos_i);

  always_comb begin
    res_w = '0;
    sat_w = 1'b0;
    case (op_i)
      OP_QADD: begin
        sat_w = add_ovf;
        res_w = add_ovf ? (a_i[DW-1] ? SMIN : SMAX) : sum;
      end
      OP_QSUB: begin
        sat_w = sub_ovf;
        res_w = sub_ovf ? (a_i[DW-1] ? SMIN : SMAX) : dif;
      end
      OP_QDBL: begin
        if ($signed(a_i) >= $signed(QPOS)) begin
          sat_w = 1'b1; res_w = SMAX;
        end else if ($signed(a_i) <= $signed(QNEG)) begin
          sat_w = 1'b1; res_w = SMIN;
        end else begin
          res_w = {a_i[DW-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        sat_w = uadd[DW];
        res_w = uadd[DW] ? {DW{1'b1}} : sum;
      end
      OP_USUB: begin
        sat_w = (b_i > a_i);
        res_w = (b_i > a_i) ? '0 : udif;
      end
      OP_SSAT: begin
        sat_w = ws[DW];
        res_w = ws[DW-1:0];
      end
      OP_USAT: begin
        sat_w = wu[DW];
        res_w = wu[DW-1:0];
      end
      OP_SSAT2: begin
        sat_w = ls[DW] | hs[DW];
        res_w = {hs[HW-1:0], ls[HW-1:0]};
      end
      OP_USAT2: begin
        sat_w = lu[DW] | hu[DW];
        res_w = {hu[HW-1:0], lu[HW-1:0]};
      end
      OP_ADDW: begin
        sat_w = add_ovf;
        res_w = sum;
      end
      default: begin
        res_w = '0;
        sat_w = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (sat_w) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign res_o      = res_w;
  assign sat_flag_o = flag_q;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DW = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            op_i,
  input logic [DW-1:0]         a_i,
  input logic [DW-1:0]         b_i,
  input logic [$clog2(DW)-1:0] pos_i,
  input logic                  clr_i,
  input logic [DW-1:0]         res_o,
  input logic                  sat_flag_o,
  input logic                  sat_w
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};
  logic [DW-1:0] lim;
  assign lim = (ONE << pos_i) - ONE;

  assert_qadd_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd1 && a_i[DW-1] == b_i[DW-1]) |-> (res_o[DW-1] == a_i[DW-1]));

  assert_uadd_nowrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd4) |-> (res_o >= a_i));

  assert_usat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd8) |-> (res_o <= lim));

  assert_set_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_w |=> sat_flag_o);

  assert_nop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 && !clr_i) |=> $stable(sat_flag_o));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && op_i == 4'd0) |=> !sat_flag_o);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag_o && !clr_i) |=> sat_flag_o);
endmodule

bind sat_alu sat_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .pos_i(pos_i), .clr_i(clr_i), .res_o(res_o), .sat_flag_o(sat_flag_o),
  .sat_w(sat_w)
);

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [4:0]  pos_i = '0;
  logic        clr_i = 1'b0;
  logic [31:0] res_o;
  logic        sat_flag_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sat_alu u_dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
                 .pos_i(pos_i), .clr_i(clr_i), .res_o(res_o), .sat_flag_o(sat_flag_o));

  // op, a, b, pos, expected result, expected flag, requirement number
  localparam int NV = 32;
  localparam logic [109:0] VEC [NV] = '{
    {4'd1, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1, 4'd1},  // R1
    {4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1, 4'd1},  // R1
    {4'd1, 32'h00000005, 32'h00000007, 5'd0, 32'h0000000C, 1'b0, 4'd1},  // R1
    {4'd2, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1, 4'd2},  // R2
    {4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1, 4'd2},  // R2
    {4'd2, 32'h0000000A, 32'h00000003, 5'd0, 32'h00000007, 1'b0, 4'd2},  // R2
    {4'd3, 32'h40000000, 32'h0, 5'd0, 32'h7FFFFFFF, 1'b1, 4'd3},         // R3
    {4'd3, 32'hC0000000, 32'h0, 5'd0, 32'h80000000, 1'b1, 4'd3},         // R3
    {4'd3, 32'h3FFFFFFF, 32'h0, 5'd0, 32'h7FFFFFFE, 1'b0, 4'd3},         // R3
    {4'd3, 32'hC0000001, 32'h0, 5'd0, 32'h80000002, 1'b0, 4'd3},         // R3
    {4'd4, 32'hFFFFFFF0, 32'h00000020, 5'd0, 32'hFFFFFFFF, 1'b1, 4'd4},  // R4
    {4'd4, 32'h00000001, 32'h00000002, 5'd0, 32'h00000003, 1'b0, 4'd4},  // R4
    {4'd5, 32'h00000003, 32'h00000005, 5'd0, 32'h00000000, 1'b1, 4'd4},  // R4
    {4'd5, 32'h00000005, 32'h00000003, 5'd0, 32'h00000002, 1'b0, 4'd4},  // R4
    {4'd6, 32'd200,      32'h0, 5'd7, 32'h0000007F, 1'b1, 4'd5},         // R5
    {4'd6, 32'hFFFFFF38, 32'h0, 5'd7, 32'hFFFFFF80, 1'b1, 4'd5},         // R5
    {4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 32'hFFFFFF80, 1'b0, 4'd5},         // R5
    {4'd6, 32'h0000007F, 32'h0, 5'd7, 32'h0000007F, 1'b0, 4'd5},         // R5
    {4'd6, 32'h00000001, 32'h0, 5'd0, 32'h00000000, 1'b1, 4'd5},         // R5
    {4'd6, 32'hFFFFFFFF, 32'h0, 5'd0, 32'hFFFFFFFF, 1'b0, 4'd5},         // R5
    {4'd8, 32'hFFFFFFFF, 32'h0, 5'd8, 32'h00000000, 1'b1, 4'd6},         // R6
    {4'd8, 32'd300,      32'h0, 5'd8, 32'h000000FF, 1'b1, 4'd6},         // R6
    {4'd8, 32'd255,      32'h0, 5'd8, 32'h000000FF, 1'b0, 4'd6},         // R6
    {4'd8, 32'h00000001, 32'h0, 5'd0, 32'h00000000, 1'b1, 4'd6},         // R6
    {4'd7, 32'h0100FF00, 32'h0, 5'd7, 32'h007FFF80, 1'b1, 4'd7},         // R7
    {4'd7, 32'h0010FFF0, 32'h0, 5'd7, 32'h0010FFF0, 1'b0, 4'd7},         // R7
    {4'd9, 32'h80000123, 32'h0, 5'd8, 32'h000000FF, 1'b1, 4'd7},         // R7
    {4'd9, 32'h00420011, 32'h0, 5'd8, 32'h00420011, 1'b0, 4'd7},         // R7
    {4'd10, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h80000000, 1'b1, 4'd8}, // R8
    {4'd10, 32'h00000002, 32'h00000003, 5'd0, 32'h00000005, 1'b0, 4'd8}, // R8
    {4'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h00000000, 1'b0, 4'd9},  // R9
    {4'd12, 32'h7FFFFFFF, 32'h00000001, 5'd3, 32'h00000000, 1'b0, 4'd9}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] p, input logic clr);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; pos_i = p; clr_i = clr;
    #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
    op_i = 4'd0; clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", {31'd0, sat_flag_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [109:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      drive(4'd0, '0, '0, '0, 1'b1);
      tick();
      drive(v[109:106], v[105:74], v[73:42], v[41:37], 1'b0);
      chk({tag, " result"}, res_o, v[36:5]);
      tick();
      chk({tag, " flag"}, {31'd0, sat_flag_o}, {31'd0, v[4]});
    end

    // R9: flag survives non-saturating work
    drive(4'd1, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0); tick();
    drive(4'd1, 32'd1, 32'd1, 5'd0, 1'b0); tick();
    drive(4'd0, '0, '0, '0, 1'b0); tick();
    chk("R9 sticky", {31'd0, sat_flag_o}, 32'd1);
    // R10: clear alone
    drive(4'd0, '0, '0, '0, 1'b1); tick();
    chk("R10 clear", {31'd0, sat_flag_o}, 32'd0);
    // R10: set wins over simultaneous clear
    drive(4'd4, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b1); tick();
    chk("R10 set wins", {31'd0, sat_flag_o}, 32'd1);
    // R11: reset clears a set flag
    rst_n = 1'b0; tick();
    chk("R11 reset", {31'd0, sat_flag_o}, 32'd0);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule